// File: doc/BRIEF.md
# Conditional Trap Evaluation Unit

This block decides whether a conditional trap fires. It compares a register operand with a second operand. The second operand is either another register or a 16-bit immediate that has been sign-extended to full width. The comparison is made both as two's-complement signed values and as unsigned values in the same cycle. The result is a vector of five raw condition flags.

A 5-bit mask picks which flags may raise the trap. Any combination of flags can be selected. The trap request is registered and appears one clock after the valid strobe. The condition vector is registered on the same strobe and stays unchanged until the next strobe.

Instruction decode and the trap handler sit outside the block. The decoder supplies the operands, the immediate, the immediate-select signal, the mask and the strobe. The trap request goes to the exception logic.

Top module: `trap_eval_unit`

## Requirements
- R1: Condition bit 0 is set when operand A is less than the right-hand operand as signed numbers, and bit 1 is set when A is greater as signed numbers.
- R2: When the two operands are equal, bit 2 is set and bits 0, 1, 3 and 4 are all clear.
- R3: Condition bit 3 is set when A is less than the right-hand operand as unsigned numbers, and bit 4 is set when A is greater as unsigned numbers.
- R4: When `imm_sel_i` is 1, the right-hand operand is `imm_i` sign-extended from bit 15 to full width, and `opb_i` is ignored. When `imm_sel_i` is 0, the right-hand operand is `opb_i`.
- R5: `trap_o` is 1 in the cycle after a cycle with `valid_i` high if and only if the bitwise AND of the conditions and `mask_i` is nonzero. `cond_o` shows those conditions from the same cycle.
- R6: A mask of 5'b00000 never produces a trap.
- R7: A mask of 5'b11111 always produces a trap for a valid request.
- R8: In the cycle after `valid_i` is low, `trap_o` is 0 and `cond_o` keeps its previous value, whatever the other inputs do.
- R9: While `rst_n` is low at a clock edge, `trap_o` and `cond_o` are cleared to 0.
- R10: In every valid result, exactly one of bits {0,1,2} is set, and exactly one of bits {2,3,4} is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Evaluate the operands presented in this cycle |
| opa_i | input | 32 | Left-hand register operand |
| opb_i | input | 32 | Right-hand register operand |
| imm_i | input | 16 | Immediate right-hand operand, sign-extended before use |
| imm_sel_i | input | 1 | 1 selects the immediate, 0 selects `opb_i` |
| mask_i | input | 5 | Trap condition mask; its bit positions match `cond_o` |
| trap_o | output | 1 | Registered trap request |
| cond_o | output | 5 | Registered raw condition flags |

## Verification
The bench sweeps pairs of operands built from the sign boundary, zero, all-ones and their neighbours, and applies every mask value to each pair.

Pairs where the signed order and the unsigned order disagree catch a design that swaps the signed and unsigned comparisons. Equal pairs catch a design that leaves an ordering flag set on equality.

Immediates 0x8000 and 0xFFFF, combined with a nonzero `opb_i`, expose zero-extension of the immediate and leakage of `opb_i` into the comparison. Idle cycles with scrambled inputs expose a condition register that loads without a strobe or a trap that fires without one.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int NCOND = 5;
  localparam int C_SLT = 0;
  localparam int C_SGT = 1;
  localparam int C_EQ  = 2;
  localparam int C_ULT = 3;
  localparam int C_UGT = 4;
  typedef logic [NCOND-1:0] cond_t;
endpackage

// File: rtl/trap_opsel.sv
module trap_opsel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic [DATA_W-1:0] reg_b,
  input  logic [IMM_W-1:0]  imm,
  input  logic              use_imm,
  output logic [DATA_W-1:0] rhs
);
  logic [DATA_W-1:0] imm_ext;

  generate
    if (DATA_W > IMM_W) begin : g_ext
      assign imm_ext = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign imm_ext = imm[DATA_W-1:0];
    end
  endgenerate

  assign rhs = use_imm ? imm_ext : reg_b;
endmodule

// File: rtl/trap_compare.sv
module trap_compare
  import trap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] lhs,
  input  logic [DATA_W-1:0] rhs,
  output cond_t             conds
);
  function automatic logic less_signed(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return $signed(x) < $signed(y);
  endfunction

  function automatic logic less_unsigned(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    return x < y;
  endfunction

  function automatic cond_t eval_conds(input logic [DATA_W-1:0] x, input logic [DATA_W-1:0] y);
    cond_t c;
    c        = '0;
    c[C_EQ]  = (x == y);
    c[C_SLT] = less_signed(x, y);
    c[C_SGT] = less_signed(y, x);
    c[C_ULT] = less_unsigned(x, y);
    c[C_UGT] = less_unsigned(y, x);
    return c;
  endfunction

  assign conds = eval_conds(lhs, rhs);
endmodule

// File: rtl/trap_eval_unit.sv
module trap_eval_unit
  import trap_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              imm_sel_i,
  input  logic [NCOND-1:0]  mask_i,
  output logic              trap_o,
  output logic [NCOND-1:0]  cond_o
);
  logic [DATA_W-1:0] rhs_w;
  cond_t             cond_w;
  logic              hit_w;
  logic              trap_q;
  cond_t             cond_q;

  trap_opsel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
    .reg_b   (opb_i),
    .imm     (imm_i),
    .use_imm (imm_sel_i),
    .rhs     (rhs_w)
  );

  trap_compare #(.DATA_W(DATA_W)) u_cmp (
    .lhs   (opa_i),
    .rhs   (rhs_w),
    .conds (cond_w)
  );

  assign hit_w = |(cond_w & mask_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trap_q <= 1'b0;
      cond_q <= '0;
    end else begin
      trap_q <= valid_i & hit_w;
      if (valid_i) cond_q <= cond_w;
    end
  end

  assign trap_o = trap_q;
  assign cond_o = cond_q;
endmodule

// File: rtl/trap_eval_chk.sv
module trap_eval_chk
  import trap_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             valid_i,
  input logic [NCOND-1:0] mask_i,
  input logic [NCOND-1:0] cond_w,
  input logic             trap_o,
  input logic [NCOND-1:0] cond_o
);
  p_trap_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> (trap_o == $past(|(cond_w & mask_i))));
  p_no_trap_zero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mask_i == '0) |=> !trap_o);
  p_trap_full_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && mask_i == '1) |=> trap_o);
  p_idle_no_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !trap_o);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> $stable(cond_o));
  p_eq_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cond_o[C_EQ] |-> (cond_o == cond_t'(1 << C_EQ)));
  p_signed_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cond_o[C_SLT], cond_o[C_SGT], cond_o[C_EQ]}));
  p_unsigned_order_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cond_o[C_ULT], cond_o[C_UGT], cond_o[C_EQ]}));
endmodule

bind trap_eval_unit trap_eval_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid_i (valid_i),
  .mask_i  (mask_i),
  .cond_w  (cond_w),
  .trap_o  (trap_o),
  .cond_o  (cond_o)
);

// File: tb/trap_eval_unit_tb.sv
module trap_eval_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] opa_i = '0, opb_i = '0;
  logic [15:0] imm_i = '0;
  logic        imm_sel_i = 1'b0;
  logic [4:0]  mask_i = '0;
  logic        trap_o;
  logic [4:0]  cond_o;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  trap_eval_unit u_dut (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opa_i(opa_i), .opb_i(opb_i),
    .imm_i(imm_i), .imm_sel_i(imm_sel_i), .mask_i(mask_i),
    .trap_o(trap_o), .cond_o(cond_o)
  );

  logic [31:0] pats [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h2, 32'hFFFF_FFFE, 32'h8000_0001};
  logic [15:0] imms [6] = '{16'h0, 16'h1, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Reference built from 64-bit integer arithmetic
  function automatic logic [4:0] ref_conds(input logic [31:0] a, input logic [31:0] r);
    longint sa, sr, ua, ur;
    sa = longint'($signed(a)); sr = longint'($signed(r));
    ua = longint'(a);          ur = longint'(r);
    return {ua > ur, ua < ur, sa == sr, sa > sr, sa < sr};
  endfunction

  // Drive one valid request, then compare the registered outputs half a cycle after the edge
  task automatic run(input logic [31:0] a, input logic [31:0] b, input logic [15:0] im,
                     input logic sel, input logic [4:0] m, input string tag);
    logic [31:0] r;
    logic [4:0]  c;
    r = sel ? 32'(longint'($signed(im))) : b;
    c = ref_conds(a, r);
    opa_i = a; opb_i = b; imm_i = im; imm_sel_i = sel; mask_i = m; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    check({tag, " cond"}, 32'(cond_o), 32'(c));
    check("R5 trap", 32'(trap_o), 32'(|(c & m)));
    if (m == 5'h00) check("R6 zero mask", 32'(trap_o), 0);
    if (m == 5'h1F) check("R7 full mask", 32'(trap_o), 1);
    if (c[2]) check("R2 equal alone", 32'(cond_o), 32'h4);
    check("R10 signed one-hot", 32'($countones(c[2:0])), 1);
    check("R10 unsigned one-hot", 32'($countones(c[4:2])), 1);
  endtask

  initial begin
    for (int i = 0; i < 150000; i++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    // R9: reset clears outputs even with a valid request pending
    valid_i = 1'b1; opa_i = 32'h5; opb_i = 32'h5; mask_i = 5'h1F;
    repeat (3) @(negedge clk);
    check("R9 reset trap", 32'(trap_o), 0);
    check("R9 reset cond", 32'(cond_o), 0);
    valid_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R3 R2: register-form sweep of every pattern pair and every mask
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++)
        for (int m = 0; m < 32; m++)
          run(pats[i], pats[j], 16'hBEEF, 1'b0, 5'(m), "R1 R3 reg");

    // R4: immediate form, opb_i is noise and must be ignored
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 6; k++)
        for (int m = 0; m < 32; m++)
          run(pats[i], ~pats[i] ^ 32'h0F0F_0000, imms[k], 1'b1, 5'(m), "R4 imm");

    // R4: 0x8000 must extend to 0xFFFF8000, which equals A
    run(32'hFFFF_8000, 32'h0, 16'h8000, 1'b1, 5'h04, "R4 neg imm");
    check("R4 neg imm eq", 32'(trap_o), 1);

    // R8: idle cycles with scrambled inputs keep cond and never trap
    run(32'h1, 32'h2, 16'h0, 1'b0, 5'h1F, "R8 setup");
    held = cond_o;
    for (int n = 0; n < 6; n++) begin
      opa_i = 32'h8000_0000 >> n; opb_i = 32'(n); mask_i = 5'h1F; imm_sel_i = n[0];
      valid_i = 1'b0;
      @(negedge clk);
      check("R8 idle trap", 32'(trap_o), 0);
      check("R8 idle cond", 32'(cond_o), 32'(held));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule